// File: doc/BRIEF.md
# DDR PHY Read Termination and Receiver Power Controller

This block sits between a DDR memory controller and its data PHY slice. It holds one PHY control word: the programmed read latency, three 2-bit local on-die-termination (ODT) codes (read, write, idle), a PHY reset bit and a dynamic receiver power-down enable. Software writes land in a shadow copy. The copy drives nothing until a later write to the SDRAM configuration register starts an update request/acknowledge exchange with the PHY. At acknowledge, the whole shadow word is copied into the active word in one cycle.

From the active word, the block tracks the window during which a read is in flight. The window opens at the read command and closes when the last read beat has returned. A read command loads a down-counter with the programmed latency plus one plus the burst length in controller cycles. Reads that overlap stretch the window to whichever end time is latest. The window selects the ODT code driven on the PHY's local ODT pins and gates power to the IO receivers.

The programmed latency equals the total read latency minus one. The total read latency lies between CAS latency + 2 and CAS latency + 7. For example, CL = 5 gives programmed values 6 to 11.

ODT code meanings:
- 00 and 01: termination off.
- 10: full Thevenin load, equal to 1x the driver impedance.
- 11: half Thevenin load, equal to 2x the driver impedance.

Top module: `phy_odt_ctrl`

## Requirements
- R1: After reset the control word reads back 0x800: dynamic power-down on, every other field 0. The update request is low, no read is in flight, and local ODT, write ODT and PHY reset all drive 0.
- R2: A control-word write lands in the shadow word only. The shadow word has these fields: latency in bits 3:0, read ODT in bits 5:4, write ODT in bits 7:6, idle ODT in bits 9:8, PHY reset in bit 10, dynamic power-down in bit 11. Readback returns the shadow word with bits 31:12 as 0. The write changes no PHY-side output.
- R3: A config write while no request is pending raises the update request on the next cycle. The request stays high until acknowledge is seen.
- R4: In a cycle where the request and acknowledge are both high, the active word takes the shadow value. The request is low from the next cycle on.
- R5: Config writes that arrive while a request is pending merge into that request. One acknowledge ends it, and no second request follows.
- R6: A read command raises the in-flight flag from the next cycle. With no other read, the flag stays high for exactly latency + 1 + BURST_CYC cycles.
- R7: A read command issued while a read is in flight extends the window to the later of the two end times, with no gap.
- R8: While a read is in flight and the data output enable is low, local ODT drives the active read ODT code.
- R9: While no read is in flight and dynamic power-down is 1, local ODT drives the active idle ODT code.
- R10: In all other cases local ODT drives the active write ODT code. These cases are: in flight with output enable high, or not in flight with dynamic power-down 0.
- R11: The receiver power enable is always 1 when dynamic power-down is 0. When it is 1, the enable equals the in-flight flag.
- R12: The PHY reset (1 = hold in reset) and write ODT outputs follow the active word and change only at an acknowledged update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_en | input | 1 | Write strobe for the PHY control word |
| ctl_wdata | input | 32 | Control word write data |
| ctl_rdata | output | 32 | Shadow control word readback |
| cfg_wr_en | input | 1 | Write strobe of the SDRAM config register; starts an update |
| upd_req | output | 1 | Update request to the PHY |
| upd_ack | input | 1 | Update acknowledge from the PHY |
| rd_cmd | input | 1 | Read command issued this cycle |
| dq_oe | input | 1 | Data output enable (write drive active) |
| rd_inflight | output | 1 | A read is in flight |
| local_odt | output | 2 | Local ODT code to the PHY |
| wr_local_odt | output | 2 | Active write ODT code to the data macros |
| rx_pwr_en | output | 1 | IO receiver power enable |
| phy_rst | output | 1 | PHY reset, active high |

## Verification
Some properties are checked on every cycle:
- The request rises only after a config write and is held until acknowledge.
- The request drops once acknowledge is seen.
- A read command always opens the window.
- The receivers are never off while a read is in flight.
- Reserved readback bits stay 0.
- The PHY reset and write ODT outputs move only at an acknowledged update.

Other behaviour can only be shown by the bench's scenarios, which run against a cycle-accurate reference model:
- the exact window lengths for single and overlapping reads;
- merging of repeated config writes into one request;
- which ODT code is chosen under each combination of output enable and power-down mode.

// File: rtl/odt_ctl_pkg.sv
package odt_ctl_pkg;
  localparam int REG_W = 32;
  localparam int LAT_W = 4;

  // Control word, LSB first: lat, rd_odt, wr_odt, idle_odt, phy_rst, dyn_pd
  typedef struct packed {
    logic             dyn_pd;
    logic             phy_rst;
    logic [1:0]       idle_odt;
    logic [1:0]       wr_odt;
    logic [1:0]       rd_odt;
    logic [LAT_W-1:0] lat;
  } phy_ctl_t;

  localparam int CTL_W = $bits(phy_ctl_t);

  localparam phy_ctl_t CTL_RST = '{dyn_pd: 1'b1, phy_rst: 1'b0, idle_odt: 2'b00,
                                   wr_odt: 2'b00, rd_odt: 2'b00, lat: '0};

  typedef enum logic {UPD_IDLE, UPD_WAIT} upd_state_e;
endpackage

// File: rtl/odt_ctl_regs.sv
module odt_ctl_regs
  import odt_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr_en,
  input  logic [REG_W-1:0] ctl_wdata,
  input  logic             cfg_wr_en,
  input  logic             upd_ack,
  output phy_ctl_t         shadow_q,
  output phy_ctl_t         active_q,
  output logic             upd_req
);
  upd_state_e st_q, st_d;
  phy_ctl_t   shadow_d, active_d;
  logic       commit;
  logic       unused_hi;

  // Reserved write bits are dropped
  assign unused_hi = ^ctl_wdata[REG_W-1:CTL_W];

  always_comb begin
    commit   = (st_q == UPD_WAIT) && upd_ack;
    shadow_d = phy_ctl_t'(ctl_wdata[CTL_W-1:0]);
    active_d = shadow_q;
    st_d     = st_q;
    case (st_q)
      UPD_IDLE: if (cfg_wr_en) st_d = UPD_WAIT;
      UPD_WAIT: if (upd_ack)   st_d = UPD_IDLE; // later config writes merge here
      default:                 st_d = UPD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= CTL_RST;
      active_q <= CTL_RST;
      st_q     <= UPD_IDLE;
    end else begin
      if (ctl_wr_en) shadow_q <= shadow_d;
      if (commit)    active_q <= active_d;
      st_q <= st_d;
    end
  end

  assign upd_req = (st_q == UPD_WAIT);
endmodule

// File: rtl/odt_rd_window.sv
module odt_rd_window #(
  parameter int LAT_W     = 4,
  parameter int BURST_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_cmd,
  input  logic [LAT_W-1:0] lat,
  output logic             inflight
);
  localparam int MAX_LOAD = (1 << LAT_W) + BURST_CYC;
  localparam int CNT_W    = $clog2(MAX_LOAD + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, dec, load;
  logic             cnt_en;

  always_comb begin
    dec    = (cnt_q == '0) ? '0 : cnt_q - CNT_W'(1);
    load   = CNT_W'(lat) + CNT_W'(BURST_CYC) + CNT_W'(1);
    // Overlapping reads keep the latest end time
    cnt_d  = (rd_cmd && (load > dec)) ? load : dec;
    cnt_en = rd_cmd || (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign inflight = (cnt_q != '0);
endmodule

// File: rtl/odt_out_mux.sv
module odt_out_mux
  import odt_ctl_pkg::*;
(
  input  phy_ctl_t   act,
  input  logic       inflight,
  input  logic       dq_oe,
  output logic [1:0] local_odt,
  output logic       rx_pwr_en
);
  logic [LAT_W-1:0] unused_lat;
  assign unused_lat = act.lat;

  always_comb begin
    if (inflight && !dq_oe)        local_odt = act.rd_odt;
    else if (act.dyn_pd && !inflight) local_odt = act.idle_odt;
    else                           local_odt = act.wr_odt;
    rx_pwr_en = act.dyn_pd ? inflight : 1'b1;
  end
endmodule

// File: rtl/phy_odt_ctrl.sv
module phy_odt_ctrl
  import odt_ctl_pkg::*;
#(
  parameter int BURST_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr_en,
  input  logic [REG_W-1:0] ctl_wdata,
  output logic [REG_W-1:0] ctl_rdata,
  input  logic             cfg_wr_en,
  output logic             upd_req,
  input  logic             upd_ack,
  input  logic             rd_cmd,
  input  logic             dq_oe,
  output logic             rd_inflight,
  output logic [1:0]       local_odt,
  output logic [1:0]       wr_local_odt,
  output logic             rx_pwr_en,
  output logic             phy_rst
);
  phy_ctl_t shadow, active;

  odt_ctl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wdata(ctl_wdata),
    .cfg_wr_en(cfg_wr_en), .upd_ack(upd_ack),
    .shadow_q(shadow), .active_q(active), .upd_req(upd_req)
  );

  odt_rd_window #(.LAT_W(LAT_W), .BURST_CYC(BURST_CYC)) u_win (
    .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .lat(active.lat),
    .inflight(rd_inflight)
  );

  odt_out_mux u_mux (
    .act(active), .inflight(rd_inflight), .dq_oe(dq_oe),
    .local_odt(local_odt), .rx_pwr_en(rx_pwr_en)
  );

  assign ctl_rdata    = REG_W'(shadow);
  assign wr_local_odt = active.wr_odt;
  assign phy_rst      = active.phy_rst;
endmodule

// File: rtl/phy_odt_ctrl_chk.sv
module phy_odt_ctrl_chk
  import odt_ctl_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr_en,
  input logic             upd_req,
  input logic             upd_ack,
  input logic             rd_cmd,
  input logic             rd_inflight,
  input logic             rx_pwr_en,
  input logic             phy_rst,
  input logic [1:0]       wr_local_odt,
  input logic [REG_W-1:0] ctl_rdata
);
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[REG_W-1:CTL_W] == '0);

  assert_req_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_req) |-> $past(cfg_wr_en));

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_req && !upd_ack) |=> upd_req);

  assert_req_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_req && upd_ack) |=> !upd_req);

  assert_window_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd |=> rd_inflight);

  assert_rx_on_in_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_inflight |-> rx_pwr_en);

  assert_active_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_req && upd_ack) |=> ($stable(phy_rst) && $stable(wr_local_odt)));
endmodule

bind phy_odt_ctrl phy_odt_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .upd_req(upd_req),
  .upd_ack(upd_ack), .rd_cmd(rd_cmd), .rd_inflight(rd_inflight),
  .rx_pwr_en(rx_pwr_en), .phy_rst(phy_rst), .wr_local_odt(wr_local_odt),
  .ctl_rdata(ctl_rdata)
);

// File: tb/phy_odt_ctrl_bench.sv
module phy_odt_ctrl_bench;
  localparam int BURST = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr_en = 1'b0;
  logic [31:0] ctl_wdata = '0;
  logic [31:0] ctl_rdata;
  logic        cfg_wr_en = 1'b0;
  logic        upd_req;
  logic        upd_ack = 1'b0;
  logic        rd_cmd = 1'b0;
  logic        dq_oe = 1'b0;
  logic        rd_inflight;
  logic [1:0]  local_odt, wr_local_odt;
  logic        rx_pwr_en, phy_rst;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 0;

  // reference model state
  int m_sh = 32'h800, m_act = 32'h800, m_cnt = 0;
  bit m_req = 0;

  phy_odt_ctrl #(.BURST_CYC(BURST)) u_phy_odt_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .cfg_wr_en(cfg_wr_en), .upd_req(upd_req),
    .upd_ack(upd_ack), .rd_cmd(rd_cmd), .dq_oe(dq_oe), .rd_inflight(rd_inflight),
    .local_odt(local_odt), .wr_local_odt(wr_local_odt), .rx_pwr_en(rx_pwr_en),
    .phy_rst(phy_rst)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sh = 32'h800; m_act = 32'h800; m_cnt = 0; m_req = 0;
    end else begin
      int nxt;
      nxt = (m_cnt > 0) ? m_cnt - 1 : 0;
      if (rd_cmd && ((m_act & 15) + 1 + BURST) > nxt) nxt = (m_act & 15) + 1 + BURST;
      m_cnt = nxt;
      if (m_req && upd_ack) begin m_act = m_sh; m_req = 0; end
      else if (!m_req && cfg_wr_en) m_req = 1;
      if (ctl_wr_en) m_sh = ctl_wdata & 32'hFFF;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      bit busy, dyn;
      int exp_odt;
      busy = (m_cnt > 0);
      dyn  = ((m_act >> 11) & 1) != 0;
      chk("R2 readback", ctl_rdata, m_sh);
      chk("R3 R5 upd_req", upd_req, m_req);
      chk("R6 R7 rd_inflight", rd_inflight, busy);
      chk("R12 phy_rst", phy_rst, (m_act >> 10) & 1);
      chk("R12 wr_local_odt", wr_local_odt, (m_act >> 6) & 3);
      chk("R11 rx_pwr_en", rx_pwr_en, dyn ? busy : 1);
      if (busy && !dq_oe) begin
        exp_odt = (m_act >> 4) & 3; chk("R8 local_odt", local_odt, exp_odt);
      end else if (dyn && !busy) begin
        exp_odt = (m_act >> 8) & 3; chk("R9 local_odt", local_odt, exp_odt);
      end else begin
        exp_odt = (m_act >> 6) & 3; chk("R10 local_odt", local_odt, exp_odt);
      end
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wr_ctl(input logic [31:0] v);
    ctl_wdata = v; ctl_wr_en = 1'b1; tick(); ctl_wr_en = 1'b0;
  endtask

  task automatic commit_cfg();
    cfg_wr_en = 1'b1; tick(); cfg_wr_en = 1'b0;
    tick(2);
    upd_ack = 1'b1; tick(); upd_ack = 1'b0;
  endtask

  task automatic read_len(input int gap, input int exp, input string tag);
    int n = 0;
    rd_cmd = 1'b1; tick(); rd_cmd = 1'b0;
    if (gap > 0) begin tick(gap - 1); rd_cmd = 1'b1; tick(); rd_cmd = 1'b0; n = gap; end
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); if (rd_inflight) n++;
      @(posedge clk); #2;
    end
    chk(tag, n, exp);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", ctl_rdata, 32'h800);
    chk("R1 upd_req", upd_req, 0);
    chk("R1 local_odt", local_odt, 0);
    chk("R1 phy_rst", phy_rst, 0);
    chk("R1 rd_inflight", rd_inflight, 0);
    cmp_on = 1;
    tick();
    // R2: lat=5 rd=10 phy_rst=1 dyn=1, reserved bits set and dropped
    wr_ctl(32'hABCD_FC25);
    tick(2);
    @(negedge clk); chk("R2 no effect phy_rst", phy_rst, 0);
    tick();
    // R3 R4: request held without ack, then commit
    cfg_wr_en = 1'b1; tick(); cfg_wr_en = 1'b0;
    tick(3);
    @(negedge clk); chk("R3 held", upd_req, 1);
    tick(); upd_ack = 1'b1; tick(); upd_ack = 1'b0;
    @(negedge clk); chk("R4 phy_rst applied", phy_rst, 1);
    chk("R4 req dropped", upd_req, 0);
    tick();
    // R6 single read: 5+1+4 = 10 cycles; R8 code checked per cycle
    read_len(0, 10, "R6 window length");
    // R7 overlap: second read 3 cycles later -> 13 cycles
    read_len(3, 13, "R7 extended window");
    // R10 output enable high during read
    dq_oe = 1'b1; read_len(0, 10, "R10 window with oe"); dq_oe = 1'b0;
    // R5 merge: lat=2 rd=11 wr=01 idle=10 rst=0 dyn=0
    wr_ctl(32'h272);
    cfg_wr_en = 1'b1; tick(); cfg_wr_en = 1'b0; tick();
    cfg_wr_en = 1'b1; tick(); cfg_wr_en = 1'b0; tick();
    upd_ack = 1'b1; tick(); upd_ack = 1'b0;
    tick(4);
    @(negedge clk); chk("R5 no second request", upd_req, 0);
    chk("R10 dyn off idle code", local_odt, 1);
    chk("R11 rx always on", rx_pwr_en, 1);
    tick();
    read_len(0, 7, "R6 window lat 2");
    // R9: same with dynamic power-down on
    wr_ctl(32'hA72);
    commit_cfg();
    tick(2);
    @(negedge clk); chk("R9 idle code", local_odt, 2);
    chk("R11 rx off idle", rx_pwr_en, 0);
    tick();
    read_len(1, 8, "R7 back-to-back");
    tick(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule